// File: doc/BRIEF.md
# Error Capture and Lock Register Block

This block keeps the error state of a logical and transport layer. Each error type has a hardware strobe. When a strobe fires, the block sets the type's sticky bit in a detect register. Three capture registers hold the attributes of the first error whose type is enabled: its address, its device ID and its packet type. After such a capture the registers lock, so the first enabled error stays on record while software looks into it.

Software reaches the block through a simple register bus. A write strobe, a word address and write data update registers on the next clock edge. Reads are combinational and change no state. Software can clear or unlock the block. For debug it can also load the capture registers with chosen values and then write a detect bit, which injects an error. A level output asks the error-reporting logic to notify software for as long as any enabled detect bit is set.

Top module: `err_capture_lock`

## Requirements
- R1: After reset, all five registers read zero and `err_notify` and `cap_locked` are low.
- R2: A hardware strobe sets its type's detect bit on the next clock edge. Detect bits stay set until software writes the detect register.
- R3: A strobe whose type bit is set in the enable register, arriving while the block is unlocked, stores `evt_addr`, `evt_devid` and `evt_ptype` into the capture registers and raises `cap_locked` on the next edge.
- R4: While the block is locked, further strobes still set detect bits but leave all capture registers unchanged.
- R5: A write to the detect register whose low NUM_TYPES bits are all zero clears every detect bit and releases the lock.
- R6: Any write to the enable register releases the lock and loads the new enable mask. The detect bits are left unchanged.
- R7: Software writes to the capture registers take effect only while the block is unlocked. While it is locked they are ignored.
- R8: A non-zero write to the detect register loads the written bits. If any written bit is enabled, the block locks and keeps the capture contents that software placed there.
- R9: `err_notify` is high exactly when some detect bit and the matching enable bit are both set.
- R10: Reads have no side effects. The word addresses are: 0 detect, 1 enable, 2 capture address, 3 capture device ID, 4 capture packet type. Addresses 5 to 7 read zero. Narrower values are zero-extended.
- R11: In a single cycle, a detect write and strobes combine to the written bits OR the strobes. A hardware capture wins over a software capture write in the same cycle. An unlocking write in the same cycle as an enabled strobe ends up locked, holding the strobe's attributes.
- R12: A strobe of a type that is not enabled sets its detect bit but neither captures nor locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NUM_TYPES | One strobe per error type |
| evt_addr | input | ADDR_W | Address attribute of the current error |
| evt_devid | input | DEVID_W | Device ID attribute of the current error |
| evt_ptype | input | PTYPE_W | Packet type attribute of the current error |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| err_notify | output | 1 | Level notification request |
| cap_locked | output | 1 | Capture registers are frozen |

## Verification
The bench goes after same-cycle collisions, which a priority mistake gets wrong:
- A clearing write that meets an enabled strobe. If the clear wins, the error is lost and the block stays unlocked.
- A capture write that races a hardware capture. If the write wins, the frozen address does not match the error.

Locked-state behaviour comes next. A design that freezes on the wrong condition lets a second error overwrite the first. A design that ignores the enable-register unlock stays stuck until the next clear.

Injection is checked with and without an enabled bit. A design that captures on a software detect write clobbers the values software staged.

A long pseudo-random run compares every port against a behavioural model on each clock.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      REG_DETECT    = 3'd0,
      REG_ENABLE    = 3'd1,
      REG_CAP_ADDR  = 3'd2,
      REG_CAP_DEVID = 3'd3,
      REG_CAP_PTYPE = 3'd4
   } errcap_reg_e;
endpackage

// File: rtl/errcap_regbus.sv
module errcap_regbus
   import errcap_pkg::*;
#(
   parameter int NUM_TYPES = 8,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int DEVID_W   = 16,
   parameter int PTYPE_W   = 4
) (
   input  logic                 bus_wr,
   input  logic [REG_AW-1:0]    bus_addr,
   input  logic [NUM_TYPES-1:0] detect_q,
   input  logic [NUM_TYPES-1:0] enable_q,
   input  logic [ADDR_W-1:0]    cap_addr_q,
   input  logic [DEVID_W-1:0]   cap_devid_q,
   input  logic [PTYPE_W-1:0]   cap_ptype_q,
   output logic                 wr_detect,
   output logic                 wr_enable,
   output logic                 wr_cap_addr,
   output logic                 wr_cap_devid,
   output logic                 wr_cap_ptype,
   output logic [DATA_W-1:0]    bus_rdata
);
   errcap_reg_e sel;
   assign sel = errcap_reg_e'(bus_addr);

   assign wr_detect    = bus_wr && (sel == REG_DETECT);
   assign wr_enable    = bus_wr && (sel == REG_ENABLE);
   assign wr_cap_addr  = bus_wr && (sel == REG_CAP_ADDR);
   assign wr_cap_devid = bus_wr && (sel == REG_CAP_DEVID);
   assign wr_cap_ptype = bus_wr && (sel == REG_CAP_PTYPE);

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_DETECT:    bus_rdata = DATA_W'(detect_q);
         REG_ENABLE:    bus_rdata = DATA_W'(enable_q);
         REG_CAP_ADDR:  bus_rdata = DATA_W'(cap_addr_q);
         REG_CAP_DEVID: bus_rdata = DATA_W'(cap_devid_q);
         REG_CAP_PTYPE: bus_rdata = DATA_W'(cap_ptype_q);
         default:       bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/errcap_lock_ctrl.sv
module errcap_lock_ctrl #(
   parameter int NUM_TYPES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_TYPES-1:0] evt_strobe,
   input  logic                 wr_detect,
   input  logic                 wr_enable,
   input  logic [NUM_TYPES-1:0] wdata_types,
   output logic [NUM_TYPES-1:0] detect_q,
   output logic [NUM_TYPES-1:0] enable_q,
   output logic                 lock_q,
   output logic                 unlock,
   output logic                 cap_load,
   output logic                 notify
);
   logic hw_hit, sw_hit, lock_held;

   assign unlock    = (wr_detect && (wdata_types == '0)) || wr_enable;
   assign lock_held = lock_q && !unlock;
   assign hw_hit    = |(evt_strobe & enable_q);
   assign sw_hit    = wr_detect && |(wdata_types & enable_q);
   assign cap_load  = hw_hit && !lock_held;
   assign notify    = |(detect_q & enable_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         detect_q <= '0;
         enable_q <= '0;
         lock_q   <= 1'b0;
      end else begin
         detect_q <= (wr_detect ? wdata_types : detect_q) | evt_strobe;
         if (wr_enable) enable_q <= wdata_types;
         lock_q   <= lock_held || hw_hit || sw_hit;
      end
   end

   a_r2_detect_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_detect |=> ((detect_q & $past(detect_q)) == $past(detect_q)));

   a_r3_enabled_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_strobe & enable_q)) |=> lock_q);

   a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_detect && wdata_types == '0 && evt_strobe == '0) |=> (detect_q == '0 && !lock_q));

   a_r12_no_spurious_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && !wr_detect && !(|(evt_strobe & enable_q))) |=> !lock_q);
endmodule

// File: rtl/errcap_capture.sv
module errcap_capture #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int DEVID_W    = 16,
   parameter int PTYPE_W    = 4,
   parameter bit KEEP_PTYPE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_load,
   input  logic               lock_q,
   input  logic               unlock,
   input  logic               wr_cap_addr,
   input  logic               wr_cap_devid,
   input  logic               wr_cap_ptype,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [ADDR_W-1:0]  evt_addr,
   input  logic [DEVID_W-1:0] evt_devid,
   input  logic [PTYPE_W-1:0] evt_ptype,
   output logic [ADDR_W-1:0]  cap_addr_q,
   output logic [DEVID_W-1:0] cap_devid_q,
   output logic [PTYPE_W-1:0] cap_ptype_q
);
   logic sw_open;
   assign sw_open = !lock_q && !cap_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr_q  <= '0;
         cap_devid_q <= '0;
      end else if (cap_load) begin
         cap_addr_q  <= evt_addr;
         cap_devid_q <= evt_devid;
      end else if (sw_open) begin
         if (wr_cap_addr)  cap_addr_q  <= wdata[ADDR_W-1:0];
         if (wr_cap_devid) cap_devid_q <= wdata[DEVID_W-1:0];
      end
   end

   generate
      if (KEEP_PTYPE) begin : g_ptype
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cap_ptype_q <= '0;
            else if (cap_load)              cap_ptype_q <= evt_ptype;
            else if (sw_open && wr_cap_ptype) cap_ptype_q <= wdata[PTYPE_W-1:0];
         end
      end else begin : g_no_ptype
         assign cap_ptype_q = '0;
      end
   endgenerate

   a_r4_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !unlock) |=> ($stable(cap_addr_q) && $stable(cap_devid_q) && $stable(cap_ptype_q)));

   a_r7_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_cap_addr && !cap_load) |=> $stable(cap_addr_q));
endmodule

// File: rtl/err_capture_lock.sv
module err_capture_lock
   import errcap_pkg::*;
#(
   parameter int NUM_TYPES  = 8,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int DEVID_W    = 16,
   parameter int PTYPE_W    = 4,
   parameter bit KEEP_PTYPE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_TYPES-1:0] evt_strobe,
   input  logic [ADDR_W-1:0]    evt_addr,
   input  logic [DEVID_W-1:0]   evt_devid,
   input  logic [PTYPE_W-1:0]   evt_ptype,
   input  logic                 bus_wr,
   input  logic [2:0]           bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 err_notify,
   output logic                 cap_locked
);
   generate
      if (NUM_TYPES < 1 || NUM_TYPES > DATA_W) begin : g_bad_types
         $error("NUM_TYPES must lie in 1..DATA_W");
      end
      if (ADDR_W > DATA_W || DEVID_W > DATA_W || PTYPE_W > DATA_W) begin : g_bad_attr
         $error("capture fields must fit in DATA_W");
      end
      if (REG_AW != 3) begin : g_bad_aw
         $error("register address width must be 3");
      end
   endgenerate

   logic [NUM_TYPES-1:0] detect_q, enable_q;
   logic [ADDR_W-1:0]    cap_addr_q;
   logic [DEVID_W-1:0]   cap_devid_q;
   logic [PTYPE_W-1:0]   cap_ptype_q;
   logic wr_detect, wr_enable, wr_cap_addr, wr_cap_devid, wr_cap_ptype;
   logic lock_q, unlock, cap_load;

   errcap_regbus #(
      .NUM_TYPES(NUM_TYPES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .DEVID_W(DEVID_W), .PTYPE_W(PTYPE_W)
   ) u_regbus (
      .bus_wr(bus_wr), .bus_addr(bus_addr),
      .detect_q(detect_q), .enable_q(enable_q),
      .cap_addr_q(cap_addr_q), .cap_devid_q(cap_devid_q), .cap_ptype_q(cap_ptype_q),
      .wr_detect(wr_detect), .wr_enable(wr_enable),
      .wr_cap_addr(wr_cap_addr), .wr_cap_devid(wr_cap_devid), .wr_cap_ptype(wr_cap_ptype),
      .bus_rdata(bus_rdata)
   );

   errcap_lock_ctrl #(.NUM_TYPES(NUM_TYPES)) u_lock (
      .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
      .wr_detect(wr_detect), .wr_enable(wr_enable),
      .wdata_types(bus_wdata[NUM_TYPES-1:0]),
      .detect_q(detect_q), .enable_q(enable_q), .lock_q(lock_q),
      .unlock(unlock), .cap_load(cap_load), .notify(err_notify)
   );

   errcap_capture #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEVID_W(DEVID_W),
      .PTYPE_W(PTYPE_W), .KEEP_PTYPE(KEEP_PTYPE)
   ) u_capture (
      .clk(clk), .rst_n(rst_n), .cap_load(cap_load), .lock_q(lock_q), .unlock(unlock),
      .wr_cap_addr(wr_cap_addr), .wr_cap_devid(wr_cap_devid), .wr_cap_ptype(wr_cap_ptype),
      .wdata(bus_wdata), .evt_addr(evt_addr), .evt_devid(evt_devid), .evt_ptype(evt_ptype),
      .cap_addr_q(cap_addr_q), .cap_devid_q(cap_devid_q), .cap_ptype_q(cap_ptype_q)
   );

   assign cap_locked = lock_q;

   a_r9_notify_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == '0) |-> !err_notify);
endmodule

// File: tb/err_capture_lock_bench.sv
module err_capture_lock_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_strobe = '0;
   logic [31:0] evt_addr = '0;
   logic [15:0] evt_devid = '0;
   logic [3:0]  evt_ptype = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        err_notify, cap_locked;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   logic [7:0]  m_det = '0, m_en = '0;
   logic [31:0] m_ca = '0;
   logic [15:0] m_cd = '0;
   logic [3:0]  m_cp = '0;
   logic        m_lock = 1'b0;

   always #10 clk = ~clk;

   err_capture_lock u_err_capture_lock (
      .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .evt_addr(evt_addr),
      .evt_devid(evt_devid), .evt_ptype(evt_ptype), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_notify(err_notify),
      .cap_locked(cap_locked)
   );

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {24'd0, m_det};
         3'd1: return {24'd0, m_en};
         3'd2: return m_ca;
         3'd3: return {16'd0, m_cd};
         3'd4: return {28'd0, m_cp};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                       input logic [7:0] ev, input logic [31:0] ea, input logic [15:0] ed,
                       input logic [3:0] ep, input string req);
      logic wdet, wen, unl, hw, sw, held;
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = wd;
      evt_strobe = ev; evt_addr = ea; evt_devid = ed; evt_ptype = ep;
      wdet = wr && a == 3'd0;
      wen  = wr && a == 3'd1;
      unl  = (wdet && wd[7:0] == 8'd0) || wen;
      hw   = (ev & m_en) != 8'd0;
      sw   = wdet && ((wd[7:0] & m_en) != 8'd0);
      held = m_lock && !unl;
      @(posedge clk);
      if (hw && !held) begin
         m_ca = ea; m_cd = ed; m_cp = ep;
      end else if (!m_lock && wr) begin
         if (a == 3'd2) m_ca = wd;
         if (a == 3'd3) m_cd = wd[15:0];
         if (a == 3'd4) m_cp = wd[3:0];
      end
      m_det  = (wdet ? wd[7:0] : m_det) | ev;
      if (wen) m_en = wd[7:0];
      m_lock = held || hw || sw;
      #1;
      check("R9", "err_notify", {31'd0, err_notify}, {31'd0, (m_det & m_en) != 8'd0});
      check(req, "cap_locked", {31'd0, cap_locked}, {31'd0, m_lock});
      check(req, "bus_rdata", bus_rdata, m_read(a));
   endtask

   task automatic rd(input logic [2:0] a, input string req);
      step(1'b0, a, 32'd0, 8'd0, 32'd0, 16'd0, 4'd0, req);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
      step(1'b1, a, d, 8'd0, 32'd0, 16'd0, 4'd0, req);
   endtask

   task automatic ev(input logic [7:0] s, input logic [31:0] ea, input logic [15:0] ed,
                     input logic [3:0] ep, input logic [2:0] a, input string req);
      step(1'b0, a, 32'd0, s, ea, ed, ep, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      #1;
      check("R1", "locked in reset", {31'd0, cap_locked}, 32'd0);
      check("R1", "notify in reset", {31'd0, err_notify}, 32'd0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      for (int i = 0; i < 8; i++) rd(3'(i), "R1");

      // R10: writes to unused addresses leave nothing behind
      wr(3'd6, 32'hFFFF_FFFF, "R10");
      for (int i = 0; i < 8; i++) rd(3'(i), "R10");

      wr(3'd1, 32'h05, "R6");
      ev(8'h02, 32'h1111_0000, 16'h0101, 4'h1, 3'd0, "R12");
      rd(3'd2, "R12");
      ev(8'h01, 32'hA5A5_0001, 16'hBEEF, 4'h7, 3'd2, "R3");
      rd(3'd3, "R3");
      rd(3'd4, "R3");
      ev(8'h04, 32'h2222_2222, 16'h3333, 4'h9, 3'd2, "R4");
      rd(3'd0, "R2");
      wr(3'd2, 32'hDEAD_0000, "R7");
      rd(3'd2, "R7");
      wr(3'd1, 32'h05, "R6");
      rd(3'd0, "R6");
      wr(3'd2, 32'hCAFE_0002, "R7");
      rd(3'd2, "R7");
      wr(3'd0, 32'h0, "R5");
      rd(3'd0, "R5");

      // R8: staged capture values, then a non-enabled and an enabled detect write
      wr(3'd2, 32'h0BAD_F00D, "R8");
      wr(3'd3, 32'h0000_4242, "R8");
      wr(3'd4, 32'h0000_000C, "R8");
      wr(3'd0, 32'h02, "R8");
      wr(3'd0, 32'h04, "R8");
      rd(3'd2, "R8");
      rd(3'd3, "R8");
      rd(3'd4, "R8");

      // R11: clear meets an enabled strobe; hw capture vs sw capture write
      step(1'b1, 3'd0, 32'h0, 8'h01, 32'h7777_0007, 16'h0777, 4'h3, "R11");
      rd(3'd2, "R11");
      wr(3'd1, 32'h01, "R11");
      step(1'b1, 3'd2, 32'h9999_9999, 8'h01, 32'h5555_0005, 16'h0555, 4'h5, "R11");
      rd(3'd2, "R11");
      step(1'b1, 3'd0, 32'h80, 8'h02, 32'h0, 16'h0, 4'h0, "R11");
      rd(3'd0, "R11");

      lf = 32'h1234_5678;
      for (int i = 0; i < 1500; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf[25:24] == 2'd0, lf[2:0], (lf[5:4] == 2'd0) ? 32'd0 : {lf[7:0], lf[31:8]},
              lf[15:8] & lf[23:16] & lf[31:24], lf ^ 32'h3C3C_3C3C, lf[27:12], lf[11:8], "R10");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule